// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Front-End

This block sits between a simple 32-bit register port and the sequencer that burns and senses a fuse array. It holds a control word, a timing word, a program-data word and a window of shadow words that mirror the fuse contents. It decides when a program or reload request may start and when an access is refused. A program request needs a per-access key. The control word can be changed either by a full write or through bit-set and bit-clear aliases. A sticky error flag blocks any further request until software clears it. Reads of protected shadow words return a fixed poison value.

Software loads a target word index together with the key into the control word, then writes the data register to start a burn. The block copies the index and data into registers facing the sequencer, raises BUSY and clears the key. BUSY stays high until the sequencer reports completion. A reload is started by setting the reload bit through the set alias. While it runs, the sequencer refills the shadow words through a dedicated load port. Lock inputs mark which words may not be programmed or written, and which may not be read.

Top module: `fuse_regfront`

## Requirements
- R1: After reset the control word, the timing word, the data word and every shadow word read 0, and neither request output is high.
- R2: The control word at offset 0x00 reads as {key[31:16], 5'b0, reload[10], error[9], busy[8], index[7:0]}. A write there replaces the index and key fields. A write at 0x04 ORs the written index and key bits in. A write at 0x08 clears the written index and key bits, and clears error when bit 9 is 1. Software cannot set bits 8 and 9.
- R3: A write to the data register (0x20) programs a word when the key field holds 0x3E77, busy and error are both 0, and the index is an unlocked word below the word count. On the next edge prog_req pulses high for one cycle, prog_addr and prog_data carry the index and the written data, busy becomes 1 and the key field reads 0.
- R4: A data-register write made without the exact key changes nothing: the data word, the control word and prog_req all keep their values.
- R5: While a program is outstanding, prog_addr, prog_data and the data word hold their values, even when the control index is rewritten or the data register is written again.
- R6: A keyed program request to a program-locked word, or to an index at or above the word count, raises no request and leaves busy at 0. It sets error and clears the key field.
- R7: A prog_done pulse while a program is outstanding clears busy.
- R8: Shadow word n reads at offset 0x400 + 0x10*n. An offset in that window with nonzero low four bits, or one past the last word, is unmapped and reads 0. Reading a read-locked word returns 0xBADABADA and sets error.
- R9: A bus write to a shadow word stores the data only when the word is not program-locked, no reload is running and error is 0. A write to a locked word, or any shadow write during a reload, sets error and leaves the word unchanged.
- R10: Writing bit 10 through the set alias while idle pulses reload_req for one cycle and sets busy and the reload bit. Both stay set until reload_done. Load-port writes replace shadow words.
- R11: While error is 1, program and reload requests are ignored, shadow reads return 0xBADABADA and shadow writes are dropped. Normal operation resumes once error is cleared.
- R12: While busy is 1, data-register writes, reload requests and timing-register writes are ignored.
- R13: The timing word at 0x10 reads back the last accepted write and drives timing_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| word_plock | input | NUM_WORDS | Per-word lock against programming and shadow writes |
| word_rlock | input | NUM_WORDS | Per-word lock against shadow reads |
| prog_req | output | 1 | One-cycle program start toward the sequencer |
| prog_addr | output | 8 | Captured word index of the program |
| prog_data | output | 32 | Captured data of the program |
| prog_done | input | 1 | Sequencer reports the program finished |
| reload_req | output | 1 | One-cycle reload start toward the sequencer |
| reload_done | input | 1 | Sequencer reports the reload finished |
| ld_en | input | 1 | Shadow load strobe from the sequencer |
| ld_idx | input | IDX_W | Shadow word being loaded |
| ld_data | input | 32 | Shadow load data |
| timing_q | output | 32 | Current timing word |

## Verification
The embedded properties assume that bus_rd and bus_wr are never asserted together, that prog_done pulses only while a program is outstanding, and that reload_done and ld_en occur only while a reload runs. The bench drives every strobe for a single cycle at the falling edge. It pulses prog_done and reload_done only after it has confirmed busy through a control-word read, and it uses the load port only inside the reload window. Under those conditions the one-cycle request pulses and the hold of the captured index and data are meaningful. The sweep covers every word of a 32-word configuration, in both the program path and the shadow path.

// File: rtl/fuse_regfront_pkg.sv
package fuse_regfront_pkg;

   // register offsets (bytes)
   localparam int unsigned OFS_CTRL    = 32'h000;
   localparam int unsigned OFS_SET     = 32'h004;
   localparam int unsigned OFS_CLR     = 32'h008;
   localparam int unsigned OFS_TIMING  = 32'h010;
   localparam int unsigned OFS_DATA    = 32'h020;
   localparam int unsigned OFS_SHADOW  = 32'h400;
   localparam int unsigned SHADOW_LG   = 4;          // 16-byte stride

   // control word field positions
   localparam int unsigned IDX_FLD_W   = 8;
   localparam int unsigned BIT_BUSY    = 8;
   localparam int unsigned BIT_ERR     = 9;
   localparam int unsigned BIT_RELOAD  = 10;
   localparam int unsigned KEY_LSB     = 16;
   localparam int unsigned KEY_W       = 16;

   localparam logic [KEY_W-1:0] UNLOCK_KEY  = 16'h3E77;
   localparam logic [31:0]      POISON_WORD = 32'hBADA_BADA;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_SET,
      SEL_CLR,
      SEL_TIMING,
      SEL_DATA,
      SEL_SHADOW
   } reg_sel_e;

   typedef struct packed {
      logic [KEY_W-1:0]     key;
      logic [4:0]           rsvd;
      logic                 reload;
      logic                 err;
      logic                 busy;
      logic [IDX_FLD_W-1:0] idx;
   } ctl_word_t;

endpackage

// File: rtl/fuse_ctl_core.sv
module fuse_ctl_core
   import fuse_regfront_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  reg_sel_e             sel,
   input  logic [31:0]          wdata,
   input  logic                 prog_blocked,
   input  logic                 sh_fault,
   input  logic                 prog_done,
   input  logic                 reload_done,
   output ctl_word_t            ctl_q,
   output logic [31:0]          timing_q,
   output logic [31:0]          data_q,
   output logic                 prog_req,
   output logic [IDX_FLD_W-1:0] prog_addr,
   output logic [31:0]          prog_data,
   output logic                 reload_req
);

   ctl_word_t nxt;
   logic      idle_ok, key_ok, prog_try, prog_go, prog_fail, reload_go;
   logic      prog_busy;
   logic      unused_bits;

   assign unused_bits = ^{wdata[15:11], wdata[BIT_BUSY]};

   assign prog_busy = ctl_q.busy && !ctl_q.reload;
   assign idle_ok   = !ctl_q.busy && !ctl_q.err;
   assign key_ok    = (ctl_q.key == UNLOCK_KEY);
   assign prog_try  = wr_en && (sel == SEL_DATA) && idle_ok && key_ok;
   assign prog_go   = prog_try && !prog_blocked;
   assign prog_fail = prog_try && prog_blocked;
   assign reload_go = wr_en && (sel == SEL_SET) && wdata[BIT_RELOAD] && idle_ok;

   always_comb begin
      nxt = ctl_q;
      if (wr_en) begin
         case (sel)
            SEL_CTRL: begin
               nxt.idx = wdata[IDX_FLD_W-1:0];
               nxt.key = wdata[KEY_LSB +: KEY_W];
            end
            SEL_SET: begin
               nxt.idx = ctl_q.idx | wdata[IDX_FLD_W-1:0];
               nxt.key = ctl_q.key | wdata[KEY_LSB +: KEY_W];
            end
            SEL_CLR: begin
               nxt.idx = ctl_q.idx & ~wdata[IDX_FLD_W-1:0];
               nxt.key = ctl_q.key & ~wdata[KEY_LSB +: KEY_W];
               if (wdata[BIT_ERR]) nxt.err = 1'b0;
            end
            default: ;
         endcase
      end
      if (prog_go) begin
         nxt.busy = 1'b1;
         nxt.key  = '0;
      end
      if (prog_fail) begin
         nxt.err = 1'b1;
         nxt.key = '0;
      end
      if (reload_go) begin
         nxt.busy   = 1'b1;
         nxt.reload = 1'b1;
      end
      if (prog_busy && prog_done) nxt.busy = 1'b0;
      if (ctl_q.reload && reload_done) begin
         nxt.busy   = 1'b0;
         nxt.reload = 1'b0;
      end
      if (sh_fault) nxt.err = 1'b1;
      nxt.rsvd = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         timing_q   <= '0;
         data_q     <= '0;
         prog_req   <= 1'b0;
         prog_addr  <= '0;
         prog_data  <= '0;
         reload_req <= 1'b0;
      end else begin
         ctl_q      <= nxt;
         prog_req   <= prog_go;
         reload_req <= reload_go;
         if (prog_go) begin
            data_q    <= wdata;
            prog_addr <= ctl_q.idx;
            prog_data <= wdata;
         end
         if (wr_en && (sel == SEL_TIMING) && !ctl_q.busy) timing_q <= wdata;
      end
   end

   // R3: a program request comes with busy held for a program
   p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> (ctl_q.busy && !ctl_q.reload));

   // R3: request is a single-cycle pulse
   p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);

   // R5: captured index and data hold while the program is outstanding
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && $past(prog_busy)) |->
         ($stable(prog_addr) && $stable(prog_data) && $stable(data_q)));

   // R6: a refused program leaves error set and busy clear
   p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_fail |=> (ctl_q.err && !ctl_q.busy && !prog_req));

   // R11: no request starts while error is pending
   p_err_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.err && !ctl_q.busy) |=> (!prog_req && !reload_req));

   // R10: reload request comes with reload and busy flags
   p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |-> (ctl_q.reload && ctl_q.busy));

endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
   import fuse_regfront_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 128,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic                 hit,
   input  logic [IDX_W-1:0]     idx,
   input  logic [31:0]          wdata,
   input  logic [NUM_WORDS-1:0] rlock,
   input  logic [NUM_WORDS-1:0] wlock,
   input  logic                 err_active,
   input  logic                 reload_active,
   input  logic                 ld_en,
   input  logic [IDX_W-1:0]     ld_idx,
   input  logic [31:0]          ld_data,
   output logic [31:0]          rdata,
   output logic                 fault
);

   logic [31:0]          mem [NUM_WORDS];
   logic [NUM_WORDS-1:0] bus_we;
   logic [NUM_WORDS-1:0] load_we;
   logic                 store_ok;

   assign store_ok = hit && wr_en && !err_active && !reload_active && !wlock[idx];
   assign fault    = hit && ((wr_en && (reload_active || wlock[idx])) ||
                             (rd_en && rlock[idx]));
   assign rdata    = (err_active || rlock[idx]) ? POISON_WORD : mem[idx];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_we
      assign bus_we[w]  = store_ok && (idx == IDX_W'(w));
      assign load_we[w] = ld_en && (ld_idx == IDX_W'(w));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WORDS; w++) mem[w] <= '0;
      end else begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (load_we[w])     mem[w] <= ld_data;
            else if (bus_we[w]) mem[w] <= wdata;
         end
      end
   end

   // R9: a bus store never coincides with a fault report
   p_store_nofault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !((|bus_we) && fault));

endmodule

// File: rtl/fuse_regfront.sv
module fuse_regfront
   import fuse_regfront_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 128,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_WORDS-1:0] word_plock,
   input  logic [NUM_WORDS-1:0] word_rlock,
   output logic                 prog_req,
   output logic [7:0]           prog_addr,
   output logic [31:0]          prog_data,
   input  logic                 prog_done,
   output logic                 reload_req,
   input  logic                 reload_done,
   input  logic                 ld_en,
   input  logic [IDX_W-1:0]     ld_idx,
   input  logic [31:0]          ld_data,
   output logic [31:0]          timing_q
);

   if (NUM_WORDS < 2 || NUM_WORDS > 256) begin : g_bad_words
      $error("fuse_regfront: NUM_WORDS must lie in 2..256");
   end
   if (ADDR_W > 31 || OFS_SHADOW + (NUM_WORDS << SHADOW_LG) > (32'd1 << ADDR_W)) begin : g_bad_span
      $error("fuse_regfront: ADDR_W too small for the shadow window");
   end

   ctl_word_t         ctl_q;
   logic [31:0]       data_q;
   logic [31:0]       sh_rdata;
   logic              sh_fault;
   logic [ADDR_W-1:0] sh_off;
   logic              sh_hit;
   logic [IDX_W-1:0]  sh_idx;
   logic              prog_blocked;
   reg_sel_e          sel;

   // shadow window decode
   assign sh_off = bus_addr - ADDR_W'(OFS_SHADOW);
   assign sh_hit = (bus_addr >= ADDR_W'(OFS_SHADOW)) &&
                   (sh_off[SHADOW_LG-1:0] == '0) &&
                   (32'(sh_off[ADDR_W-1:SHADOW_LG]) < 32'(NUM_WORDS));
   assign sh_idx = sh_off[SHADOW_LG +: IDX_W];

   always_comb begin
      sel = SEL_NONE;
      if (sh_hit) sel = SEL_SHADOW;
      else begin
         case (bus_addr)
            ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
            ADDR_W'(OFS_SET):    sel = SEL_SET;
            ADDR_W'(OFS_CLR):    sel = SEL_CLR;
            ADDR_W'(OFS_TIMING): sel = SEL_TIMING;
            ADDR_W'(OFS_DATA):   sel = SEL_DATA;
            default:             sel = SEL_NONE;
         endcase
      end
   end

   // program target out of range or locked
   assign prog_blocked = (32'(ctl_q.idx) >= 32'(NUM_WORDS)) ||
                         word_plock[ctl_q.idx[IDX_W-1:0]];

   fuse_ctl_core u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (bus_wr),
      .sel          (sel),
      .wdata        (bus_wdata),
      .prog_blocked (prog_blocked),
      .sh_fault     (sh_fault),
      .prog_done    (prog_done),
      .reload_done  (reload_done),
      .ctl_q        (ctl_q),
      .timing_q     (timing_q),
      .data_q       (data_q),
      .prog_req     (prog_req),
      .prog_addr    (prog_addr),
      .prog_data    (prog_data),
      .reload_req   (reload_req)
   );

   fuse_shadow_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_en         (bus_rd),
      .wr_en         (bus_wr),
      .hit           (sh_hit),
      .idx           (sh_idx),
      .wdata         (bus_wdata),
      .rlock         (word_rlock),
      .wlock         (word_plock),
      .err_active    (ctl_q.err),
      .reload_active (ctl_q.reload),
      .ld_en         (ld_en),
      .ld_idx        (ld_idx),
      .ld_data       (ld_data),
      .rdata         (sh_rdata),
      .fault         (sh_fault)
   );

   always_comb begin
      case (sel)
         SEL_CTRL, SEL_SET, SEL_CLR: bus_rdata = ctl_q;
         SEL_TIMING:                 bus_rdata = timing_q;
         SEL_DATA:                   bus_rdata = data_q;
         SEL_SHADOW:                 bus_rdata = sh_rdata;
         default:                    bus_rdata = '0;
      endcase
   end

   // R8: reading a read-locked shadow word raises error
   p_poison_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sh_hit && word_rlock[sh_idx]) |=> ctl_q.err);

endmodule

// File: tb/test_fuse_regfront.sv
module test_fuse_regfront;

   localparam int NW = 32;
   localparam int AW = 12;
   localparam int IW = $clog2(NW);
   localparam logic [31:0] KEY    = 32'h3E77_0000;
   localparam logic [31:0] POISON = 32'hBADA_BADA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NW-1:0] word_plock = '0, word_rlock = '0;
   logic          prog_req, reload_req;
   logic [7:0]    prog_addr;
   logic [31:0]   prog_data, timing_q;
   logic          prog_done = 1'b0, reload_done = 1'b0, ld_en = 1'b0;
   logic [IW-1:0] ld_idx = '0;
   logic [31:0]   ld_data = '0;

   int total = 0;
   int bad   = 0;
   logic [31:0] rv;

   always #5 clk = ~clk;

   fuse_regfront #(.NUM_WORDS(NW), .ADDR_W(AW)) i_fuse_regfront (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .word_plock(word_plock), .word_rlock(word_rlock),
      .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
      .prog_done(prog_done), .reload_req(reload_req), .reload_done(reload_done),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .timing_q(timing_q)
   );

   function automatic logic [31:0] pat_p(input int w);
      return 32'h1357_0000 ^ (32'(w) * 32'h0001_0203);
   endfunction
   function automatic logic [31:0] pat_s(input int w);
      return 32'hF00D_0000 | (32'(w) * 32'h0000_0111);
   endfunction
   function automatic logic [AW-1:0] sh_at(input int w);
      return AW'(32'h400 + 16 * w);
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_prog_done();
      @(negedge clk); prog_done = 1'b1;
      @(negedge clk); prog_done = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bread(12'h000, rv); chk(rv, 32'h0, "R1 ctrl");
      bread(12'h010, rv); chk(rv, 32'h0, "R1 timing");
      bread(12'h020, rv); chk(rv, 32'h0, "R1 data");
      bread(sh_at(0), rv); chk(rv, 32'h0, "R1 shadow0");
      chk({30'b0, prog_req, reload_req}, 32'h0, "R1 requests");

      // R13 timing
      bwrite(12'h010, 32'h1234_5678);
      bread(12'h010, rv); chk(rv, 32'h1234_5678, "R13 timing readback");
      chk(timing_q, 32'h1234_5678, "R13 timing_q");

      // R2 aliases
      bwrite(12'h000, 32'h0000_0005);
      bwrite(12'h004, 32'h0000_00F0);
      bread(12'h000, rv); chk(rv, 32'h0000_00F5, "R2 set or");
      bwrite(12'h004, 32'h0000_0300);
      bread(12'h000, rv); chk(rv, 32'h0000_00F5, "R2 status not settable");
      bwrite(12'h008, 32'h0000_0011);
      bread(12'h000, rv); chk(rv, 32'h0000_00E4, "R2 clr");
      bwrite(12'h004, 32'hFFFF_0000);
      bread(12'h000, rv); chk(rv, 32'hFFFF_00E4, "R2 set key");
      bwrite(12'h008, 32'hFFFF_0000);
      bread(12'h000, rv); chk(rv, 32'h0000_00E4, "R2 clr key");

      // R4 no key / wrong key
      bwrite(12'h000, 32'h0000_0003);
      bwrite(12'h020, 32'h0000_AAAA);
      chk({31'b0, prog_req}, 32'h0, "R4 no req nokey");
      bread(12'h020, rv); chk(rv, 32'h0, "R4 data unchanged");
      bwrite(12'h000, 32'h3E76_0003);
      bwrite(12'h020, 32'h0000_BBBB);
      chk({31'b0, prog_req}, 32'h0, "R4 no req badkey");
      bread(12'h000, rv); chk(rv, 32'h3E76_0003, "R4 ctrl unchanged");

      // R3 / R5 / R7 sweep over every word
      for (int w = 0; w < NW; w++) begin
         bwrite(12'h000, KEY | 32'(w));
         bwrite(12'h020, pat_p(w));
         chk({31'b0, prog_req}, 32'h1, "R3 req pulse");
         chk({24'b0, prog_addr}, 32'(w), "R3 prog_addr");
         chk(prog_data, pat_p(w), "R3 prog_data");
         bread(12'h000, rv); chk(rv, 32'h100 | 32'(w), "R3 busy and key cleared");
         chk({31'b0, prog_req}, 32'h0, "R3 req one cycle");
         bwrite(12'h000, KEY | 32'h1F);
         bwrite(12'h020, ~pat_p(w));
         chk({31'b0, prog_req}, 32'h0, "R12 no req while busy");
         chk({24'b0, prog_addr}, 32'(w), "R5 addr held");
         chk(prog_data, pat_p(w), "R5 data held");
         bread(12'h020, rv); chk(rv, pat_p(w), "R5 data reg held");
         pulse_prog_done();
         bread(12'h000, rv); chk(rv, 32'h3E77_001F, "R7 busy cleared");
         bwrite(12'h000, 32'h0);
      end

      // R12 timing and reload ignored while busy
      bwrite(12'h000, KEY | 32'h1);
      bwrite(12'h020, 32'h55);
      bwrite(12'h010, 32'h0);
      bread(12'h010, rv); chk(rv, 32'h1234_5678, "R12 timing held");
      bwrite(12'h004, 32'h400);
      chk({31'b0, reload_req}, 32'h0, "R12 no reload while busy");
      bread(12'h000, rv); chk(rv, 32'h101, "R12 ctrl while busy");
      pulse_prog_done();
      bwrite(12'h000, 32'h0);

      // R6 locked and out-of-range targets
      word_plock[7] = 1'b1;
      bwrite(12'h000, KEY | 32'h7);
      bwrite(12'h020, 32'hFFFF_FFFF);
      chk({31'b0, prog_req}, 32'h0, "R6 locked no req");
      bread(12'h000, rv); chk(rv, 32'h207, "R6 locked error");
      bwrite(12'h008, 32'h200);
      bread(12'h000, rv); chk(rv, 32'h007, "R2 error cleared");
      word_plock[7] = 1'b0;
      bwrite(12'h000, KEY | 32'd40);
      bwrite(12'h020, 32'h1);
      chk({31'b0, prog_req}, 32'h0, "R6 range no req");
      bread(12'h000, rv); chk(rv, 32'h228, "R6 range error");
      bwrite(12'h008, 32'h200);
      bwrite(12'h000, 32'h0);

      // R8 / R9 shadow sweep
      for (int w = 0; w < NW; w++) bwrite(sh_at(w), pat_s(w));
      for (int w = 0; w < NW; w++) begin
         bread(sh_at(w), rv); chk(rv, pat_s(w), "R8 shadow readback");
      end
      word_plock[5] = 1'b1;
      bwrite(sh_at(5), 32'h0BAD_0005);
      bread(12'h000, rv); chk(rv, 32'h200, "R9 locked write error");
      bwrite(12'h008, 32'h200);
      bread(sh_at(5), rv); chk(rv, pat_s(5), "R9 locked word kept");
      word_plock[5] = 1'b0;
      word_rlock[9] = 1'b1;
      bread(sh_at(9), rv); chk(rv, POISON, "R8 poison");
      bread(12'h000, rv); chk(rv, 32'h200, "R8 read lock error");
      bwrite(12'h008, 32'h200);
      word_rlock[9] = 1'b0;
      bread(sh_at(9), rv); chk(rv, pat_s(9), "R8 unlocked read");
      bread(12'h408, rv); chk(rv, 32'h0, "R8 unaligned unmapped");
      bwrite(12'h408, 32'hDEAD_0000);
      bread(sh_at(0), rv); chk(rv, pat_s(0), "R8 unaligned write dropped");
      bread(sh_at(NW), rv); chk(rv, 32'h0, "R8 past end unmapped");
      bread(12'h000, rv); chk(rv, 32'h0, "R8 no error from unmapped");

      // R11 behaviour while error pending
      bwrite(12'h000, KEY | 32'd40);
      bwrite(12'h020, 32'h1);
      bwrite(12'h000, KEY | 32'h3);
      bwrite(12'h020, 32'h1);
      chk({31'b0, prog_req}, 32'h0, "R11 program ignored");
      bread(12'h000, rv); chk(rv, 32'h3E77_0203, "R11 ctrl with error");
      bwrite(12'h004, 32'h400);
      chk({31'b0, reload_req}, 32'h0, "R11 reload ignored");
      bwrite(sh_at(3), 32'h0000_FFFF);
      bread(sh_at(3), rv); chk(rv, POISON, "R11 read poison");
      bwrite(12'h008, 32'h3E77_0200);
      bread(12'h000, rv); chk(rv, 32'h3, "R11 error cleared");
      bread(sh_at(3), rv); chk(rv, pat_s(3), "R11 write was dropped");
      bwrite(12'h000, 32'h0);

      // R10 reload
      bwrite(12'h004, 32'h400);
      chk({31'b0, reload_req}, 32'h1, "R10 reload pulse");
      bread(12'h000, rv); chk(rv, 32'h500, "R10 reload busy");
      chk({31'b0, reload_req}, 32'h0, "R10 pulse one cycle");
      bwrite(sh_at(4), 32'hDEAD_BEEF);
      bread(12'h000, rv); chk(rv, 32'h700, "R9 write during reload error");
      pulse_prog_done();
      bread(12'h000, rv); chk(rv, 32'h700, "R10 prog_done no effect");
      @(negedge clk); ld_en = 1'b1; ld_idx = IW'(2); ld_data = 32'h2222_2222;
      @(negedge clk); ld_en = 1'b0;
      @(negedge clk); reload_done = 1'b1;
      @(negedge clk); reload_done = 1'b0;
      bread(12'h000, rv); chk(rv, 32'h200, "R10 reload done");
      bwrite(12'h008, 32'h200);
      bread(sh_at(4), rv); chk(rv, pat_s(4), "R9 reload write dropped");
      bread(sh_at(2), rv); chk(rv, 32'h2222_2222, "R10 load port");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule